// File: doc/BRIEF.md
# Ring-Ordered Thread Sequencer

This block controls a fixed ring of execution slots that run the threads of one sequential program. A tail pointer marks the slot that receives the next thread. A head pointer marks the slot that holds the oldest thread not yet retired. When a requester asks for a thread and the tail slot is free, the block grants the request. It starts the next thread number of the program sequence on that slot and moves the tail one step around the ring.

Each slot reports completion on its own done line. Retirement happens only at the head. A thread that finishes early keeps its slot occupied until every older thread has been retired. Retirement therefore follows program order, not the order in which threads complete.

Each physical element can carry several virtual slots. The ring holds `NUM_PE * VSLOTS` positions, and ring position p runs on element p mod `NUM_PE`. Occupancy is tracked with a counter, so an empty ring and a full ring are never confused.

Top module: `seq_ring_top`

## Requirements
- R1: A synchronous reset (`rst` high) sets every slot free, places head and tail at slot 0 and clears the thread sequence number. After reset `alloc_gnt` and `retire_o` are low, and the first grant starts thread 0 on slot 0.
- R2: `alloc_gnt` is high in exactly the cycles where `alloc_req` is high and the tail slot is free. In such a cycle `start_o` has only bit `tail` set and `start_tid_o` carries the new thread number. In every other cycle `start_o` is zero.
- R3: Granted thread numbers are consecutive: 0, 1, 2, and so on, wrapping modulo 2^`TID_W`.
- R4: The tail visits slots in ring order 0, 1, …, N-1 and then returns to 0, with N = `NUM_PE*VSLOTS`.
- R5: When all N slots hold an unretired thread, running or finished, no request is granted.
- R6: `retire_o` is high in a cycle exactly when the head slot holds a finished thread. In that cycle `retire_tid_o` and `retire_slot_o` give that thread and that slot. At the next clock edge the slot becomes free and the head advances one step.
- R7: A done pulse on a slot that is not the head marks its thread finished without retiring it. Retirement waits until all older threads have retired, and then one finished thread retires per cycle.
- R8: A `done_i` bit for a slot that is free, or that already holds a finished thread, has no effect.
- R9: A grant and a retirement can take place in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| alloc_req | input | 1 | Request to start the next thread |
| alloc_gnt | output | 1 | Request accepted this cycle |
| start_o | output | N | One-hot launch strobe for the tail slot |
| start_tid_o | output | TID_W | Thread number being launched |
| done_i | input | N | Per-slot completion pulses |
| retire_o | output | 1 | Head thread retires this cycle |
| retire_tid_o | output | TID_W | Thread number being retired |
| retire_slot_o | output | $clog2(N) | Slot being retired |

## Verification
The assertions make no assumption about `done_i`: they must hold when done bits arrive on free slots, on running slots and on finished slots. The only thing they take for granted is that reset has been applied once. The stimulus therefore drives done bits on every kind of slot. It includes directed pulses on free and already-finished slots and random pulses on slots that are not running. It also holds `alloc_req` high while the ring is full, so the no-grant path is exercised under back-pressure.

// File: rtl/seq_ring_pkg.sv
package seq_ring_pkg;

  typedef enum logic [1:0] {
    SLOT_FREE = 2'd0,
    SLOT_BUSY = 2'd1,
    SLOT_FIN  = 2'd2
  } slot_state_e;

  // Advance one position around a ring of n slots.
  function automatic int unsigned ring_step(input int unsigned idx, input int unsigned n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction

  // Thread number of the oldest unretired thread.
  function automatic int unsigned oldest_tid(input int unsigned seq, input int unsigned occ,
                                             input int unsigned modulus);
    return (seq + modulus - (occ % modulus)) % modulus;
  endfunction

endpackage

// File: rtl/seq_ring_slot.sv
module seq_ring_slot
  import seq_ring_pkg::*;
#(
  parameter int TID_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             launch,
  input  logic [TID_W-1:0] launch_tid,
  input  logic             fin,
  input  logic             release_i,
  output slot_state_e      st_o,
  output logic [TID_W-1:0] tid_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_o  <= SLOT_FREE;
      tid_o <= '0;
    end else if (launch && st_o == SLOT_FREE) begin
      st_o  <= SLOT_BUSY;
      tid_o <= launch_tid;
    end else if (fin && st_o == SLOT_BUSY) begin
      st_o  <= SLOT_FIN;
    end else if (release_i && st_o == SLOT_FIN) begin
      st_o  <= SLOT_FREE;
    end
  end

  // R2: the ring only launches into a free slot
  a_r2_launch_free: assert property (@(posedge clk) disable iff (rst)
    launch |-> st_o == SLOT_FREE);

  // R7: a finished thread keeps its slot until released from the head
  a_r7_fin_held: assert property (@(posedge clk) disable iff (rst)
    (st_o == SLOT_FIN && !release_i) |=> st_o == SLOT_FIN);

  // R8: done on a free slot does nothing
  a_r8_free_ignores_done: assert property (@(posedge clk) disable iff (rst)
    (st_o == SLOT_FREE && !launch) |=> st_o == SLOT_FREE);

  // R3: the stored thread number only changes on launch
  a_r3_tid_stable: assert property (@(posedge clk) disable iff (rst)
    !launch |=> $stable(tid_o));

endmodule

// File: rtl/seq_ring_ptr.sv
module seq_ring_ptr
  import seq_ring_pkg::*;
#(
  parameter int N  = 4,
  parameter int SW = 2,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv_tail,
  input  logic          adv_head,
  output logic [SW-1:0] head_o,
  output logic [SW-1:0] tail_o,
  output logic [CW-1:0] count_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      head_o  <= '0;
      tail_o  <= '0;
      count_o <= '0;
    end else begin
      if (adv_tail) tail_o <= SW'(ring_step(int'(tail_o), N));
      if (adv_head) head_o <= SW'(ring_step(int'(head_o), N));
      if (adv_tail && !adv_head)      count_o <= count_o + 1'b1;
      else if (adv_head && !adv_tail) count_o <= count_o - 1'b1;
    end
  end

  // R5: occupancy never exceeds the ring size
  a_r5_count_bound: assert property (@(posedge clk) disable iff (rst)
    count_o <= CW'(N));

  // R6: nothing retires from an empty ring
  a_r6_no_retire_empty: assert property (@(posedge clk) disable iff (rst)
    adv_head |-> count_o != '0);

  // R4: the tail steps to the next ring position
  a_r4_tail_step: assert property (@(posedge clk) disable iff (rst)
    adv_tail |=> tail_o == SW'(ring_step(int'($past(tail_o)), N)));

  // R6: the head steps to the next ring position
  a_r6_head_step: assert property (@(posedge clk) disable iff (rst)
    adv_head |=> head_o == SW'(ring_step(int'($past(head_o)), N)));

  // R1: an empty ring has head equal to tail
  a_r1_empty_aligned: assert property (@(posedge clk) disable iff (rst)
    count_o == '0 |-> head_o == tail_o);

endmodule

// File: rtl/seq_ring_top.sv
module seq_ring_top
  import seq_ring_pkg::*;
#(
  parameter int NUM_PE = 2,
  parameter int VSLOTS = 2,
  parameter int TID_W  = 4,
  localparam int N  = NUM_PE * VSLOTS,
  localparam int SW = (N > 1) ? $clog2(N) : 1,
  localparam int CW = $clog2(N + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc_req,
  output logic             alloc_gnt,
  output logic [N-1:0]     start_o,
  output logic [TID_W-1:0] start_tid_o,
  input  logic [N-1:0]     done_i,
  output logic             retire_o,
  output logic [TID_W-1:0] retire_tid_o,
  output logic [SW-1:0]    retire_slot_o
);

  localparam int TID_MOD = 1 << TID_W;

  logic [SW-1:0]    head, tail;
  logic [CW-1:0]    occ;
  logic [TID_W-1:0] seq_q;
  logic [N-1:0]     slot_free, slot_fin, slot_release;
  logic [TID_W-1:0] slot_tid [N];

  // named internal events
  logic alloc_fire, retire_fire;

  assign alloc_fire  = alloc_req && slot_free[tail];
  assign retire_fire = slot_fin[head];

  assign alloc_gnt     = alloc_fire;
  assign start_tid_o   = seq_q;
  assign retire_o      = retire_fire;
  assign retire_tid_o  = slot_tid[head];
  assign retire_slot_o = head;

  always_comb begin
    start_o      = '0;
    slot_release = '0;
    if (alloc_fire)  start_o[tail]      = 1'b1;
    if (retire_fire) slot_release[head] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)             seq_q <= '0;
    else if (alloc_fire) seq_q <= seq_q + 1'b1;
  end

  for (genvar s = 0; s < N; s++) begin : g_slot
    slot_state_e st;
    seq_ring_slot #(.TID_W(TID_W)) u_slot (
      .clk       (clk),
      .rst       (rst),
      .launch    (start_o[s]),
      .launch_tid(seq_q),
      .fin       (done_i[s]),
      .release_i (slot_release[s]),
      .st_o      (st),
      .tid_o     (slot_tid[s])
    );
    assign slot_free[s] = (st == SLOT_FREE);
    assign slot_fin[s]  = (st == SLOT_FIN);
  end

  seq_ring_ptr #(.N(N), .SW(SW), .CW(CW)) u_ptr (
    .clk     (clk),
    .rst     (rst),
    .adv_tail(alloc_fire),
    .adv_head(retire_fire),
    .head_o  (head),
    .tail_o  (tail),
    .count_o (occ)
  );

  // R2: at most one launch strobe
  a_r2_start_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(start_o));

  // R5: a full ring grants nothing
  a_r5_full_blocks: assert property (@(posedge clk) disable iff (rst)
    occ == CW'(N) |-> !alloc_gnt);

  // R3: each grant consumes exactly one sequence number
  a_r3_seq_step: assert property (@(posedge clk) disable iff (rst)
    alloc_fire |=> seq_q == $past(seq_q) + 1'b1);

  // R6: the retiring thread is always the oldest one issued
  a_r6_retire_oldest: assert property (@(posedge clk) disable iff (rst)
    retire_o |-> retire_tid_o == TID_W'(oldest_tid(int'(seq_q), int'(occ), TID_MOD)));

endmodule

// File: tb/tb_seq_ring_top.sv
module tb_seq_ring_top;

  localparam int CLK_P  = 10;
  localparam int NUM_PE = 2;
  localparam int VSLOTS = 2;
  localparam int TID_W  = 4;
  localparam int N      = NUM_PE * VSLOTS;
  localparam int SW     = $clog2(N);

  logic             clk = 1'b0;
  logic             rst;
  logic             alloc_req;
  logic             alloc_gnt;
  logic [N-1:0]     start_o;
  logic [TID_W-1:0] start_tid_o;
  logic [N-1:0]     done_i;
  logic             retire_o;
  logic [TID_W-1:0] retire_tid_o;
  logic [SW-1:0]    retire_slot_o;

  seq_ring_top #(.NUM_PE(NUM_PE), .VSLOTS(VSLOTS), .TID_W(TID_W)) dut (
    .clk(clk), .rst(rst), .alloc_req(alloc_req), .alloc_gnt(alloc_gnt),
    .start_o(start_o), .start_tid_o(start_tid_o), .done_i(done_i),
    .retire_o(retire_o), .retire_tid_o(retire_tid_o), .retire_slot_o(retire_slot_o)
  );

  always #(CLK_P/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model: 0 free, 1 running, 2 finished
  int mst [N];
  int mtid[N];
  int mhead, mtail, mseq;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic req, input logic [N-1:0] dn, input string tag);
    int exp_start;
    bit eg, er;
    @(negedge clk);
    alloc_req = req;
    done_i    = dn;
    #(CLK_P/4);
    eg = req && (mst[mtail] == 0);
    er = (mst[mhead] == 2);
    exp_start = eg ? (1 << mtail) : 0;
    chk(alloc_gnt == eg, tag, "alloc_gnt", int'(alloc_gnt), int'(eg));
    chk(int'(start_o) == exp_start, tag, "start_o", int'(start_o), exp_start);
    if (eg) chk(int'(start_tid_o) == mseq, tag, "start_tid_o", int'(start_tid_o), mseq);
    chk(retire_o == er, tag, "retire_o", int'(retire_o), int'(er));
    if (er) begin
      chk(int'(retire_tid_o) == mtid[mhead], tag, "retire_tid_o", int'(retire_tid_o), mtid[mhead]);
      chk(int'(retire_slot_o) == mhead, tag, "retire_slot_o", int'(retire_slot_o), mhead);
    end
    @(posedge clk);
    for (int s = 0; s < N; s++)
      if (dn[s] && mst[s] == 1) mst[s] = 2;
    if (er) begin
      mst[mhead] = 0;
      mhead = (mhead + 1) % N;
    end
    if (eg) begin
      mst[mtail]  = 1;
      mtid[mtail] = mseq;
      mseq  = (mseq + 1) % (1 << TID_W);
      mtail = (mtail + 1) % N;
    end
  endtask

  initial begin
    rst = 1'b1; alloc_req = 1'b0; done_i = '0;
    for (int s = 0; s < N; s++) begin mst[s] = 0; mtid[s] = 0; end
    mhead = 0; mtail = 0; mseq = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    step(1'b0, 4'b0000, "R1");   // idle after reset
    step(1'b1, 4'b0000, "R1");   // thread 0 on slot 0
    step(1'b1, 4'b0000, "R4");
    step(1'b1, 4'b0000, "R4");
    step(1'b1, 4'b0000, "R4");   // ring now full
    step(1'b1, 4'b0000, "R5");   // no grant while full
    step(1'b0, 4'b0100, "R7");   // younger thread finishes early
    step(1'b0, 4'b0000, "R7");   // still not retired
    step(1'b0, 4'b0100, "R8");   // done on finished slot ignored
    step(1'b1, 4'b0001, "R5");   // head finishes, ring still full
    step(1'b1, 4'b0010, "R6");   // head retires
    step(1'b1, 4'b0000, "R9");   // retire and grant together
    step(1'b1, 4'b0000, "R7");   // early thread retires in order
    step(1'b0, 4'b1111, "R6");
    repeat (6) step(1'b0, 4'b1111, "R6");  // drain
    step(1'b0, 4'b1111, "R8");   // done on free slots
    step(1'b0, 4'b0000, "R8");   // no retirement appears
    step(1'b1, 4'b0000, "R4");

    for (int c = 0; c < 600; c++) begin
      logic [N-1:0] dn;
      logic rq;
      rq = ($urandom % 4) != 0;
      dn = '0;
      for (int s = 0; s < N; s++)
        if ($urandom % 3 == 0) dn[s] = 1'b1;
      step(rq, dn, "R3");
    end

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 100000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule